// File: doc/BRIEF.md
# Dual-Clock First-Word-Fall-Through FIFO

This block moves 36-bit words from a producer running on one clock to a consumer running on an unrelated clock. The producer offers a word with `wr_en`. The word is taken on a `wr_clk` edge only while `in_ready` is high. On the consumer side the oldest word is moved ahead of time into an output register. `out_ready` then announces it, so the consumer sees data before it asks for it. Asserting `rd_en` on a `rd_clk` edge consumes the presented word and, when more data is stored, brings the next word forward on the same edge.

Each side keeps its own binary pointer and a Gray-coded copy of it. Only the Gray copy crosses to the other clock, through a two-stage synchronizer. Two threshold flags give early warning, each in its own clock domain:
- `almost_full_n` on the write side, against a margin Y.
- `almost_empty_n` on the read side, against a margin X.

Both margins are sampled from input pins while the local reset is high and are held for the rest of the run.

Top module: `dcf_fifo`

## Requirements
- R1: While its reset is high, each side samples its margin input. On leaving reset `in_ready`, `out_ready` and `almost_empty_n` are low and `almost_full_n` is high. Margin input changes after reset have no effect.
- R2: A word written into an empty FIFO shows on `rd_data` with `out_ready` high after the third `rd_clk` rising edge that follows the write edge. It does not show after the second.
- R3: While `out_ready` is high and `rd_en` is low, `out_ready` stays high and `rd_data` does not change.
- R4: While `out_ready` is low, `rd_en` is ignored. `rd_data` keeps the last word read, and later words are not lost.
- R5: Storage is DEPTH words of memory plus the output register (257 words at the default depth). When the FIFO is full, `in_ready` is low, and writes offered while `in_ready` is low are dropped without moving the write pointer.
- R6: Pointers cross the clock boundary Gray-coded, changing by at most one bit per edge. After a read frees space in a full FIFO, `in_ready` is still low after the first `wr_clk` edge and high after the second.
- R7: The write-side level is the number of words written minus the number moved into the output register. `almost_full_n` is high exactly while that level is at most DEPTH-(Y+1).
- R8: `almost_empty_n` is high exactly while the number of words in memory, not counting the output register, is greater than X.
- R9: Words leave in the order written with every bit unchanged, for all-zero, all-one, alternating and single-bit patterns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Producer clock |
| wr_rst | input | 1 | Synchronous active-high reset, write side |
| wr_en | input | 1 | Offer `wr_data` on this edge |
| wr_data | input | 36 | Word to store |
| in_ready | output | 1 | Space available; a write is taken only when high |
| almost_full_n | output | 1 | High while level is at most DEPTH-(Y+1) |
| full_margin | input | 8 | Margin Y, sampled during `wr_rst` |
| rd_clk | input | 1 | Consumer clock |
| rd_rst | input | 1 | Synchronous active-high reset, read side |
| rd_en | input | 1 | Consume the presented word on this edge |
| rd_data | output | 36 | Output register |
| out_ready | output | 1 | `rd_data` holds an unread word |
| almost_empty_n | output | 1 | High while more than X words wait in memory |
| empty_margin | input | 8 | Margin X, sampled during `rd_rst` |

## Verification
A table of bursts exercises the almost-empty threshold and data integrity together. The bursts vary in length around the margin X and carry seeds of all zeros, all ones, alternating bits and single set bits, so a wrong threshold is told apart from a corrupted or reordered word.

Single-word writes into an empty FIFO measure the fall-through latency edge by edge. Idle periods and reads against an empty FIFO separate holding the word from dropping it.

A fill past capacity pins down three things:
- the almost-full boundary, one word on each side of it;
- the exact number of words accepted, which includes the output register;
- the two-edge return of `in_ready`.

Margins are changed after reset to show that only the sampled values count.

// File: rtl/dcf_pkg.sv
`timescale 1ns/1ps
package dcf_pkg;
    localparam int PTR_MAX = 16;
    localparam int DATA_W_DEF = 36;
    localparam int DEPTH_DEF = 256;

    typedef logic [PTR_MAX-1:0] ptr_wide_t;

    function automatic ptr_wide_t to_gray(ptr_wide_t b);
        return b ^ (b >> 1);
    endfunction

    function automatic ptr_wide_t from_gray(ptr_wide_t g);
        ptr_wide_t b;
        b[PTR_MAX-1] = g[PTR_MAX-1];
        for (int i = PTR_MAX - 2; i >= 0; i--) begin
            b[i] = b[i+1] ^ g[i];
        end
        return b;
    endfunction
endpackage

// File: rtl/dcf_sync.sv
`timescale 1ns/1ps
module dcf_sync #(
    parameter int W = 9
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage1;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1 <= '0;
            q      <= '0;
        end else begin
            stage1 <= d;
            q      <= stage1;
        end
    end
endmodule

// File: rtl/dcf_ram.sv
`timescale 1ns/1ps
module dcf_ram #(
    parameter int DW = 36,
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int WORDS = 1 << AW;

    logic [DW-1:0] mem [WORDS];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/dcf_wr_ctl.sv
`timescale 1ns/1ps
module dcf_wr_ctl #(
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [AW:0]   rgray_s,
    input  logic [AW-1:0] margin_in,
    output logic [AW:0]   wbin,
    output logic [AW:0]   wgray,
    output logic          we,
    output logic          in_ready,
    output logic          almost_full_n
);
    import dcf_pkg::*;

    localparam int PW = AW + 1;
    localparam logic [AW+1:0] DEPTH_W = (AW+2)'(1 << AW);

    logic          alive;
    logic [AW-1:0] margin_q;
    logic [AW:0]   rbin_s;
    logic [AW:0]   level;
    logic [AW+1:0] level_plus;
    logic [AW:0]   wbin_nx;

    assign rbin_s     = PW'(from_gray(PTR_MAX'(rgray_s)));
    assign level      = wbin - rbin_s;
    assign level_plus = {1'b0, level} + {2'b00, margin_q};
    assign in_ready   = alive & ~level[AW];
    assign we         = wr_en & in_ready;
    assign wbin_nx    = wbin + PW'(1);
    assign almost_full_n = level_plus < DEPTH_W;

    always_ff @(posedge clk) begin
        if (rst) begin
            alive    <= 1'b0;
            wbin     <= '0;
            wgray    <= '0;
            margin_q <= margin_in;
        end else begin
            alive <= 1'b1;
            if (we) begin
                wbin  <= wbin_nx;
                wgray <= PW'(to_gray(PTR_MAX'(wbin_nx)));
            end
        end
    end
endmodule

// File: rtl/dcf_rd_ctl.sv
`timescale 1ns/1ps
module dcf_rd_ctl #(
    parameter int DW = 36,
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          rd_en,
    input  logic [AW:0]   wgray_s,
    input  logic [AW-1:0] margin_in,
    input  logic [DW-1:0] mem_rdata,
    output logic [AW:0]   rbin,
    output logic [AW:0]   rgray,
    output logic [DW-1:0] rd_data,
    output logic          out_ready,
    output logic          almost_empty_n
);
    import dcf_pkg::*;

    localparam int PW = AW + 1;

    logic [AW-1:0] margin_q;
    logic [AW:0]   wbin_s;
    logic [AW:0]   avail;
    logic [AW:0]   rbin_nx;
    logic          mem_empty;
    logic          load;

    assign wbin_s    = PW'(from_gray(PTR_MAX'(wgray_s)));
    assign avail     = wbin_s - rbin;
    assign mem_empty = (avail == '0);
    assign load      = ~mem_empty & (~out_ready | rd_en);
    assign rbin_nx   = rbin + PW'(1);
    assign almost_empty_n = avail > {1'b0, margin_q};

    always_ff @(posedge clk) begin
        if (rst) begin
            rbin      <= '0;
            rgray     <= '0;
            rd_data   <= '0;
            out_ready <= 1'b0;
            margin_q  <= margin_in;
        end else if (load) begin
            rd_data   <= mem_rdata;
            out_ready <= 1'b1;
            rbin      <= rbin_nx;
            rgray     <= PW'(to_gray(PTR_MAX'(rbin_nx)));
        end else if (rd_en) begin
            out_ready <= 1'b0;
        end
    end
endmodule

// File: rtl/dcf_fifo.sv
`timescale 1ns/1ps
module dcf_fifo #(
    parameter int DATA_W = dcf_pkg::DATA_W_DEF,
    parameter int DEPTH  = dcf_pkg::DEPTH_DEF,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic              wr_clk,
    input  logic              wr_rst,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic              in_ready,
    output logic              almost_full_n,
    input  logic [AW-1:0]     full_margin,
    input  logic              rd_clk,
    input  logic              rd_rst,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data,
    output logic              out_ready,
    output logic              almost_empty_n,
    input  logic [AW-1:0]     empty_margin
);
    logic [AW:0]       wbin, wgray, wgray_s;
    logic [AW:0]       rbin, rgray, rgray_s;
    logic              we;
    logic [DATA_W-1:0] mem_rdata;

    dcf_wr_ctl #(.AW(AW)) u_wr (
        .clk(wr_clk), .rst(wr_rst), .wr_en(wr_en), .rgray_s(rgray_s),
        .margin_in(full_margin), .wbin(wbin), .wgray(wgray), .we(we),
        .in_ready(in_ready), .almost_full_n(almost_full_n)
    );

    dcf_rd_ctl #(.DW(DATA_W), .AW(AW)) u_rd (
        .clk(rd_clk), .rst(rd_rst), .rd_en(rd_en), .wgray_s(wgray_s),
        .margin_in(empty_margin), .mem_rdata(mem_rdata), .rbin(rbin),
        .rgray(rgray), .rd_data(rd_data), .out_ready(out_ready),
        .almost_empty_n(almost_empty_n)
    );

    dcf_ram #(.DW(DATA_W), .AW(AW)) u_ram (
        .clk(wr_clk), .we(we), .waddr(wbin[AW-1:0]), .wdata(wr_data),
        .raddr(rbin[AW-1:0]), .rdata(mem_rdata)
    );

    dcf_sync #(.W(AW+1)) u_w2r (
        .clk(rd_clk), .rst(rd_rst), .d(wgray), .q(wgray_s)
    );

    dcf_sync #(.W(AW+1)) u_r2w (
        .clk(wr_clk), .rst(wr_rst), .d(rgray), .q(rgray_s)
    );
endmodule

// File: rtl/dcf_fifo_chk.sv
`timescale 1ns/1ps
module dcf_fifo_chk #(
    parameter int DW = 36,
    parameter int AW = 8
) (
    input logic          wr_clk,
    input logic          wr_rst,
    input logic          wr_en,
    input logic          in_ready,
    input logic [AW:0]   wbin,
    input logic [AW:0]   wgray,
    input logic          rd_clk,
    input logic          rd_rst,
    input logic          rd_en,
    input logic          out_ready,
    input logic [DW-1:0] rd_data,
    input logic [AW:0]   rgray
);
    // R5: an offered write while not ready leaves the write pointer alone
    a_r5_drop_when_full: assert property (@(posedge wr_clk) disable iff (wr_rst)
        (wr_en && !in_ready) |=> $stable(wbin));

    // R6: write-side Gray pointer moves by at most one bit per edge
    a_r6_wr_gray_step: assert property (@(posedge wr_clk) disable iff (wr_rst)
        $countones(wgray ^ $past(wgray)) <= 1);

    // R6: read-side Gray pointer moves by at most one bit per edge
    a_r6_rd_gray_step: assert property (@(posedge rd_clk) disable iff (rd_rst)
        $countones(rgray ^ $past(rgray)) <= 1);

    // R3: an unread presented word stays put
    a_r3_hold_word: assert property (@(posedge rd_clk) disable iff (rd_rst)
        (out_ready && !rd_en) |=> (out_ready && $stable(rd_data)));

    // R4: with nothing presented, the output register changes only by a new load
    a_r4_keep_last: assert property (@(posedge rd_clk) disable iff (rd_rst)
        !out_ready |=> (out_ready || $stable(rd_data)));
endmodule

bind dcf_fifo dcf_fifo_chk #(.DW(DATA_W), .AW(AW)) u_chk (
    .wr_clk(wr_clk), .wr_rst(wr_rst), .wr_en(wr_en), .in_ready(in_ready),
    .wbin(wbin), .wgray(wgray), .rd_clk(rd_clk), .rd_rst(rd_rst),
    .rd_en(rd_en), .out_ready(out_ready), .rd_data(rd_data), .rgray(rgray)
);

// File: tb/tb_dcf_fifo.sv
`timescale 1ns/10ps
module tb_dcf_fifo;
    localparam int DW = 36;
    localparam int DEPTH = 256;
    localparam int AW = 8;
    localparam int MARGIN = 4;

    typedef struct packed {
        logic [DW-1:0] seed;
        logic [7:0]    count;
        logic          exp_ae_n;
    } vec_t;

    localparam vec_t VECS [5] = '{
        '{seed: 36'h0_0000_0000, count: 8'd1, exp_ae_n: 1'b0},
        '{seed: 36'hF_FFFF_FFF0, count: 8'd5, exp_ae_n: 1'b0},
        '{seed: 36'hA_5A5A_5A5A, count: 8'd6, exp_ae_n: 1'b1},
        '{seed: 36'h5_A5A5_A5A0, count: 8'd9, exp_ae_n: 1'b1},
        '{seed: 36'h8_0000_0001, count: 8'd3, exp_ae_n: 1'b0}
    };

    logic          wr_clk = 0, rd_clk = 0;
    logic          wr_rst = 1, rd_rst = 1;
    logic          wr_en = 0, rd_en = 0;
    logic [DW-1:0] wr_data = '0;
    logic [AW-1:0] full_margin = '0, empty_margin = '0;
    logic          in_ready, almost_full_n, out_ready, almost_empty_n;
    logic [DW-1:0] rd_data;

    int checks = 0;
    int fails = 0;
    bit finished = 0;

    always #5 wr_clk = ~wr_clk;
    always #6.5 rd_clk = ~rd_clk;

    dcf_fifo dut (
        .wr_clk(wr_clk), .wr_rst(wr_rst), .wr_en(wr_en), .wr_data(wr_data),
        .in_ready(in_ready), .almost_full_n(almost_full_n),
        .full_margin(full_margin), .rd_clk(rd_clk), .rd_rst(rd_rst),
        .rd_en(rd_en), .rd_data(rd_data), .out_ready(out_ready),
        .almost_empty_n(almost_empty_n), .empty_margin(empty_margin)
    );

    task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    task automatic do_reset();
        wr_rst = 1; rd_rst = 1; wr_en = 0; rd_en = 0;
        full_margin = AW'(MARGIN); empty_margin = AW'(MARGIN);
        repeat (4) @(posedge wr_clk);
        repeat (4) @(posedge rd_clk);
        #0.2;
        check("R1 in_ready in reset", 64'(in_ready), 64'd0);
        check("R1 out_ready in reset", 64'(out_ready), 64'd0);
        check("R1 almost_empty_n in reset", 64'(almost_empty_n), 64'd0);
        check("R1 almost_full_n in reset", 64'(almost_full_n), 64'd1);
        @(posedge wr_clk); #0.2 wr_rst = 0;
        @(posedge rd_clk); #0.2 rd_rst = 0;
        repeat (3) @(posedge wr_clk);
        #0.2;
        // R1: margins already sampled; later changes must not matter
        full_margin = '0; empty_margin = '0;
    endtask

    task automatic write_word(logic [DW-1:0] d);
        wr_en = 1; wr_data = d;
        @(posedge wr_clk); #0.2;
        wr_en = 0;
    endtask

    task automatic read_expect(logic [DW-1:0] exp, string tag);
        for (int i = 0; i < 12 && !out_ready; i++) begin
            @(posedge rd_clk); #0.2;
        end
        check({tag, " out_ready"}, 64'(out_ready), 64'd1);
        check({tag, " data"}, 64'(rd_data), 64'(exp));
        rd_en = 1;
        @(posedge rd_clk); #0.2;
        rd_en = 0;
    endtask

    initial begin
        #2_000_000;
        fails++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        int acc;
        do_reset();

        // R2: fall-through latency into an empty FIFO
        write_word(36'h1_2345_6789);
        @(posedge rd_clk); @(posedge rd_clk); #0.2;
        check("R2 not ready after two rd edges", 64'(out_ready), 64'd0);
        @(posedge rd_clk); #0.2;
        check("R2 ready after third rd edge", 64'(out_ready), 64'd1);
        check("R2 data after third rd edge", 64'(rd_data), 64'h1_2345_6789);

        // R3: idle reads keep the word presented
        repeat (5) @(posedge rd_clk);
        #0.2;
        check("R3 still ready while idle", 64'(out_ready), 64'd1);
        check("R3 data held while idle", 64'(rd_data), 64'h1_2345_6789);
        read_expect(36'h1_2345_6789, "R3 consume");
        check("R4 empty after last read", 64'(out_ready), 64'd0);

        // R4: reads against an empty FIFO are ignored
        rd_en = 1;
        repeat (5) @(posedge rd_clk);
        #0.2 rd_en = 0;
        check("R4 stays not ready", 64'(out_ready), 64'd0);
        check("R4 last word kept", 64'(rd_data), 64'h1_2345_6789);
        write_word(36'h0_0BAD_F00D);
        read_expect(36'h0_0BAD_F00D, "R4 later word not lost");

        // R8 and R9: bursts around the almost-empty margin
        foreach (VECS[v]) begin
            for (int i = 0; i < int'(VECS[v].count); i++)
                write_word(VECS[v].seed + DW'(i));
            repeat (8) @(posedge rd_clk);
            #0.2;
            check($sformatf("R8 almost_empty_n row %0d", v),
                  64'(almost_empty_n), 64'(VECS[v].exp_ae_n));
            for (int i = 0; i < int'(VECS[v].count); i++)
                read_expect(VECS[v].seed + DW'(i), $sformatf("R9 row %0d", v));
            check($sformatf("R4 drained row %0d", v), 64'(out_ready), 64'd0);
            check($sformatf("R4 last kept row %0d", v), 64'(rd_data),
                  64'(VECS[v].seed + DW'(VECS[v].count) - DW'(1)));
        end

        // R7 and R5: fill past capacity
        do_reset();
        acc = 0;
        for (int i = 0; i < 252; i++) begin
            if (in_ready) acc++;
            write_word(DW'(i));
        end
        repeat (4) @(posedge wr_clk);
        #0.2;
        check("R7 level DEPTH-(Y+1) not almost full", 64'(almost_full_n), 64'd1);
        if (in_ready) acc++;
        write_word(DW'(252));
        check("R7 one more is almost full", 64'(almost_full_n), 64'd0);
        wr_en = 1;
        for (int i = 253; i < 260; i++) begin
            wr_data = DW'(i);
            if (in_ready) acc++;
            @(posedge wr_clk); #0.2;
        end
        wr_en = 0;
        check("R5 words accepted", 64'(acc), 64'(DEPTH + 1));
        check("R5 in_ready low when full", 64'(in_ready), 64'd0);

        // R6: one read frees space; in_ready returns on the second wr edge
        @(posedge rd_clk); #0.2;
        check("R6 head word", 64'(rd_data), 64'd0);
        rd_en = 1;
        @(posedge rd_clk); #0.2;
        rd_en = 0;
        @(posedge wr_clk); #0.2;
        check("R6 still full after first wr edge", 64'(in_ready), 64'd0);
        @(posedge wr_clk); #0.2;
        check("R6 ready after second wr edge", 64'(in_ready), 64'd1);

        // R5 and R9: drain; dropped words never appear
        for (int i = 1; i <= DEPTH; i++)
            read_expect(DW'(i), "R9 drain order");
        repeat (4) @(posedge rd_clk);
        #0.2;
        check("R5 dropped words absent", 64'(out_ready), 64'd0);
        check("R5 last accepted word kept", 64'(rd_data), 64'(DEPTH));

        summary();
    end
endmodule